// File: doc/BRIEF.md
# Three-Step Pipelined Complex Multiplier

This block multiplies two complex numbers in fixed point. It uses three real multipliers where the schoolbook form needs four. Each operand is a signed real part and a signed imaginary part of `N` bits. One `in_valid` strobe qualifies all four values. The block can accept a new operand pair on every clock cycle. Three register stages later, the full-precision real and imaginary parts of the product come out together with `out_valid`.

The work is split into three steps:
- Step one forms the two cross-free partial products `p1 = a_re*b_re` and `p2 = a_im*b_im`, and the two operand sums `s1 = a_re + a_im` and `s2 = b_re + b_im`.
- Step two forms the real part `p1 - p2`, the sum `d = p1 + p2`, and the third product `s = s1*s2`.
- Step three forms the imaginary part `s - d`. It holds the real part for one more stage so that both parts leave in the same cycle.

The block is the arithmetic element inside a matrix-inversion datapath for Hermitian matrices. It has no backpressure. The caller keeps every result that is flagged valid.

Top module: `cmul3_pipe`

## Requirements
- R1: A synchronous active-high `rst` clears every valid bit in the pipeline. While `rst` is high and in the cycles right after it, `out_valid` is 0 until a valid input has had time to pass through the pipeline.
- R2: When `out_valid` is 1, `y_re` equals `a_re*b_re - a_im*b_im` of the matching input, as a two's-complement value `2N+2` bits wide.
- R3: When `out_valid` is 1, `y_im` equals `a_re*b_im + a_im*b_re` of the matching input, as a two's-complement value `2N+2` bits wide.
- R4: The latency is exactly three cycles. An input sampled with `in_valid` at clock edge k produces `out_valid` = 1 after edge k+3.
- R5: The block accepts a new operand pair on every cycle. Back-to-back valid inputs give back-to-back results in the same order.
- R6: No overflow for any input. With every input at the most negative value, `-2^(N-1)`, the block gives `y_re` = 0 and `y_im` = `2^(2N-1)`.
- R7: When either operand is zero, both `y_re` and `y_im` are 0.
- R8: A cycle with `in_valid` = 0 produces no result. `out_valid` is 0 exactly three cycles later, and the data on the inputs in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the four operand inputs |
| a_re | input | N | Real part of operand A, signed |
| a_im | input | N | Imaginary part of operand A, signed |
| b_re | input | N | Real part of operand B, signed |
| b_im | input | N | Imaginary part of operand B, signed |
| out_valid | output | 1 | Qualifies `y_re` and `y_im` |
| y_re | output | 2N+2 | Real part of the product, signed |
| y_im | output | 2N+2 | Imaginary part of the product, signed |

## Verification
Two things meet in the same cycle in this block. A new operand pair enters step one while older pairs are in steps two and three. A bubble, where `in_valid` is low, must also pass through without disturbing its neighbours. The bench provokes this with long back-to-back bursts that have bubbles scattered among them, and with an extreme-value pair placed directly next to ordinary pairs. A scoreboard queue compares each result with the four-multiplier formula and with its issue cycle plus three. Any result that arrives with an empty queue counts as a result made from a bubble.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;
    // Number of register stages between the operand inputs and the result
    localparam int unsigned LATENCY = 3;

    // Step identifiers, one per pipeline register stage
    typedef enum logic [1:0] {
        STEP_SPLIT   = 2'd0,
        STEP_COMBINE = 2'd1,
        STEP_FINISH  = 2'd2
    } step_e;
endpackage

// File: rtl/cmul3_split.sv
// Step one: the two direct products and the two operand sums
module cmul3_split #(
    parameter int unsigned N = 16,
    localparam int unsigned PW = 2 * N,
    localparam int unsigned SW = N + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v_in,
    input  logic signed [N-1:0]  ar,
    input  logic signed [N-1:0]  ai,
    input  logic signed [N-1:0]  br,
    input  logic signed [N-1:0]  bi,
    output logic                 v_q,
    output logic signed [PW-1:0] p1_q,
    output logic signed [PW-1:0] p2_q,
    output logic signed [SW-1:0] s1_q,
    output logic signed [SW-1:0] s2_q
);
    logic signed [PW-1:0] p1_n, p2_n;
    logic signed [SW-1:0] s1_n, s2_n;

    always_comb begin
        p1_n = ar * br;
        p2_n = ai * bi;
        s1_n = SW'(ar) + SW'(ai);
        s2_n = SW'(br) + SW'(bi);
    end

    always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= v_in;
    end

    always_ff @(posedge clk) begin
        p1_q <= p1_n;
        p2_q <= p2_n;
        s1_q <= s1_n;
        s2_q <= s2_n;
    end
endmodule

// File: rtl/cmul3_combine.sv
// Step two: real part, product-sum and the single cross product
module cmul3_combine #(
    parameter int unsigned N = 16,
    localparam int unsigned PW = 2 * N,
    localparam int unsigned SW = N + 1,
    localparam int unsigned W  = 2 * N + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v_in,
    input  logic signed [PW-1:0] p1,
    input  logic signed [PW-1:0] p2,
    input  logic signed [SW-1:0] s1,
    input  logic signed [SW-1:0] s2,
    output logic                 v_q,
    output logic signed [W-1:0]  re_q,
    output logic signed [W-1:0]  d_q,
    output logic signed [W-1:0]  s_q
);
    logic signed [W-1:0] p1_x, p2_x, re_n, d_n, s_n;

    always_comb begin
        p1_x = W'(p1);
        p2_x = W'(p2);
        re_n = p1_x - p2_x;
        d_n  = p1_x + p2_x;
        s_n  = s1 * s2;
    end

    always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= v_in;
    end

    always_ff @(posedge clk) begin
        re_q <= re_n;
        d_q  <= d_n;
        s_q  <= s_n;
    end
endmodule

// File: rtl/cmul3_finish.sv
// Step three: imaginary part; real part delayed to stay aligned
module cmul3_finish #(
    parameter int unsigned N = 16,
    localparam int unsigned W = 2 * N + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                v_in,
    input  logic signed [W-1:0] re,
    input  logic signed [W-1:0] d,
    input  logic signed [W-1:0] s,
    output logic                v_q,
    output logic signed [W-1:0] re_q,
    output logic signed [W-1:0] im_q
);
    always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= v_in;
    end

    always_ff @(posedge clk) begin
        re_q <= re;
        im_q <= s - d;
    end

    // R2: a true real part never needs the top guard bit
    a_r2_re_headroom: assert property (@(posedge clk) disable iff (rst)
        v_q |-> (re_q[W-1] == re_q[W-2]));

    // R3: a true imaginary part never needs the top guard bit
    a_r3_im_headroom: assert property (@(posedge clk) disable iff (rst)
        v_q |-> (im_q[W-1] == im_q[W-2]));
endmodule

// File: rtl/cmul3_pipe.sv
module cmul3_pipe
    import cmul3_pkg::*;
#(
    parameter int unsigned N = 16,
    localparam int unsigned PW = 2 * N,
    localparam int unsigned SW = N + 1,
    localparam int unsigned W  = 2 * N + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [N-1:0] a_re,
    input  logic signed [N-1:0] a_im,
    input  logic signed [N-1:0] b_re,
    input  logic signed [N-1:0] b_im,
    output logic                out_valid,
    output logic signed [W-1:0] y_re,
    output logic signed [W-1:0] y_im
);
    logic                 v1, v2;
    logic signed [PW-1:0] p1, p2;
    logic signed [SW-1:0] s1, s2;
    logic signed [W-1:0]  re2, d2, s2p;

    cmul3_split #(.N(N)) u_split (
        .clk(clk), .rst(rst), .v_in(in_valid),
        .ar(a_re), .ai(a_im), .br(b_re), .bi(b_im),
        .v_q(v1), .p1_q(p1), .p2_q(p2), .s1_q(s1), .s2_q(s2)
    );

    cmul3_combine #(.N(N)) u_combine (
        .clk(clk), .rst(rst), .v_in(v1),
        .p1(p1), .p2(p2), .s1(s1), .s2(s2),
        .v_q(v2), .re_q(re2), .d_q(d2), .s_q(s2p)
    );

    cmul3_finish #(.N(N)) u_finish (
        .clk(clk), .rst(rst), .v_in(v2),
        .re(re2), .d(d2), .s(s2p),
        .v_q(out_valid), .re_q(y_re), .im_q(y_im)
    );

    // Cycles since reset, saturating at the latency; guards the $past window
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)                     warm <= '0;
        else if (warm != 2'(LATENCY)) warm <= warm + 2'd1;
    end

    // R1: reset empties the pipeline
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R4 / R8: out_valid mirrors in_valid exactly three cycles later
    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'(LATENCY)) |-> (out_valid == $past(in_valid, 3)));
endmodule

// File: tb/sim_cmul3_pipe.sv
module sim_cmul3_pipe;
    localparam int N = 16;
    localparam int W = 2 * N + 2;
    localparam time TCLK = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [N-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic out_valid;
    logic signed [W-1:0] y_re, y_im;

    cmul3_pipe #(.N(N)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .out_valid(out_valid), .y_re(y_re), .y_im(y_im)
    );

    always #(TCLK / 2) clk = ~clk;

    typedef struct {
        longint re;
        longint im;
        longint due;
        int     tag;
    } item_t;

    item_t queue_q[$];
    int checks = 0;
    int errors = 0;
    longint cyc = 0;
    bit rst_phase = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // tag: 2 = ordinary, 6 = most negative, 7 = zero operand
    task automatic send(input bit v, input longint ar, input longint ai,
                        input longint br, input longint bi, input int tag);
        item_t it;
        @(negedge clk);
        in_valid = v;
        a_re = N'(ar); a_im = N'(ai); b_re = N'(br); b_im = N'(bi);
        if (v) begin
            it.re  = ar * br - ai * bi;
            it.im  = ar * bi + ai * br;
            it.due = cyc + 3;
            it.tag = tag;
            queue_q.push_back(it);
        end
    endtask

    // Monitor: compare every valid result with the scoreboard head
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (queue_q.size() == 0) begin
                check(1'b0, rst_phase ? "R1" : "R8", 1, 0);
            end else begin
                item_t it;
                longint gr, gi;
                it = queue_q.pop_front();
                gr = longint'(y_re);
                gi = longint'(y_im);
                check(gr == it.re, it.tag == 6 ? "R6 re" : it.tag == 7 ? "R7 re" : "R2", gr, it.re);
                check(gi == it.im, it.tag == 6 ? "R6 im" : it.tag == 7 ? "R7 im" : "R3", gi, it.im);
                check(cyc == it.due, "R4/R5 timing", cyc, it.due);
            end
        end
    end

    localparam longint MN = -(64'sd1 <<< (N - 1));
    localparam longint MX = (64'sd1 <<< (N - 1)) - 1;

    initial begin : stim
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset", out_valid, 0);
        rst = 1'b0;
        // R7: zero operands
        send(1, 0, 0, 1234, -77, 7);
        send(1, MN, MX, 0, 0, 7);
        // R6: all inputs most negative, directly between ordinary pairs
        send(1, 3, -5, 7, 11, 2);
        send(1, MN, MN, MN, MN, 6);
        send(1, MX, MX, MX, MX, 2);
        send(1, MN, MX, MX, MN, 2);
        send(1, MX, MN, MN, MX, 2);
        // R8: bubbles carrying junk data
        send(0, 999, -999, 111, 222, 0);
        send(0, MN, MN, MN, MN, 0);
        send(1, -1, -1, -1, -1, 2);
        // R5: long back-to-back burst with scattered bubbles
        for (int i = 0; i < 200; i++) begin
            bit v;
            v = ($urandom_range(0, 4) != 0);
            send(v, longint'($signed(N'($urandom))), longint'($signed(N'($urandom))),
                 longint'($signed(N'($urandom))), longint'($signed(N'($urandom))), 2);
        end
        send(0, 0, 0, 0, 0, 0);
        repeat (5) @(negedge clk);
        check(queue_q.size() == 0, "R5 drained", queue_q.size(), 0);
        // R1: reset mid-stream discards results in flight
        send(1, 5, 6, 7, 8, 2);
        send(1, 9, 10, 11, 12, 2);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        rst_phase = 1'b1;
        queue_q.delete();
        @(negedge clk);
        check(out_valid == 1'b0, "R1 during reset", out_valid, 0);
        rst = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1 after reset", out_valid, 0);
        end
        rst_phase = 1'b0;
        send(1, MN, MN, MN, MN, 6);
        send(0, 0, 0, 0, 0, 0);
        repeat (5) @(negedge clk);
        check(queue_q.size() == 0, "R4 final drain", queue_q.size(), 0);
        done = 1'b1;
    end

    initial begin : finish_blk
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule